// File: doc/BRIEF.md
# Trap Vector and Window Adjuster

When a processor takes a trap, this block works out where the handler is fetched from and which register window becomes current. The handler address is built from a 9-bit trap type, the trap level after it has been raised, and one of two base registers. The normal base is used in ordinary operation. The hypervisor base is used when the hypervisor-mode flag is set. The next-fetch address always follows the handler address by one instruction word.

The same trap type also decides how the current window pointer moves. A clean-window trap steps the pointer back by one. A spill trap steps it back past the windows that can still be saved. A fill trap steps it forward by one. Every step wraps within the configured number of windows, and all other trap types leave the pointer unchanged.

The block also reports which range the trap type falls into: spill, fill, software trap or hypervisor software trap. With the default configuration, all results are captured on the trap-take strobe and presented one cycle later with a valid pulse. A parameter selects a purely combinational variant instead.

Top module: `trap_vector_unit`

## Requirements
- R1: With hyper_mode_i high, pc_o equals hbase_i with bits 13:0 cleared, OR'd with trap_type_i placed at bits 13:5.
- R2: With hyper_mode_i low, pc_o equals tbase_i with bits 14:0 cleared, with bit 14 set when trap_level_i is greater than 1, and with trap_type_i placed at bits 13:5.
- R3: npc_o always equals pc_o plus 4.
- R4: Trap type 0x024 (clean window) gives cwp_o = cwp_i minus 1, modulo NWIN, so a pointer of 0 becomes NWIN-1.
- R5: A trap type whose bits 8:6 equal 3'b010 (0x080–0x0BF, spill) gives cwp_o = (cwp_i − cansave_i − 2) modulo NWIN, with negative differences wrapping.
- R6: A trap type whose bits 8:6 equal 3'b011 (0x0C0–0x0FF, fill) gives cwp_o = cwp_i plus 1, modulo NWIN, so NWIN-1 becomes 0.
- R7: Every other trap type leaves cwp_o equal to cwp_i.
- R8: The group flags are set as follows, and at most one is set at a time:
  - is_spill_o for types 0x080–0x0BF;
  - is_fill_o for types 0x0C0–0x0FF;
  - is_swtrap_o for types 0x100–0x17F;
  - is_hswtrap_o for types 0x180–0x1FE.
  Type 0x1FF and types below 0x080 set no flag.
- R9: In the registered variant, the outputs load on a rising clock edge where take_i is high, and valid_o is high in the following cycle only. While take_i is low, the outputs hold their values and valid_o is low.
- R10: While rst_n is low, pc_o, npc_o, cwp_o, every group flag and valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Trap-take strobe |
| trap_type_i | input | 9 | Trap type |
| trap_level_i | input | TLW | Trap level after increment |
| tbase_i | input | AW | Normal trap base |
| hbase_i | input | AW | Hypervisor trap base |
| hyper_mode_i | input | 1 | Use hypervisor base |
| cwp_i | input | CW | Current window pointer |
| cansave_i | input | CW | Count of windows that can be saved |
| pc_o | output | AW | Handler fetch address |
| npc_o | output | AW | Next fetch address |
| cwp_o | output | CW | Adjusted window pointer |
| is_spill_o | output | 1 | Trap type is a spill |
| is_fill_o | output | 1 | Trap type is a fill |
| is_swtrap_o | output | 1 | Trap type is a software trap |
| is_hswtrap_o | output | 1 | Trap type is a hypervisor software trap |
| valid_o | output | 1 | Results were loaded in the previous cycle |

## Verification
The window arithmetic assumes that cwp_i and cansave_i are both below NWIN whenever take_i is high, and an assertion states this as an input condition. The spill formula relies on that bound so that adding twice NWIN before subtracting can never underflow. Every vector the bench applies keeps both pointers inside 0..NWIN-1 for the default eight windows. The bench still drives the largest can-save value together with a zero pointer, so the deepest negative wrap is exercised.

// File: rtl/tvw_pkg.sv
package tvw_pkg;
   localparam int TT_W = 9;

   localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
   localparam logic [2:0]      GRP_SPILL    = 3'b010;
   localparam logic [2:0]      GRP_FILL     = 3'b011;

   typedef struct packed {
      logic hswtrap;
      logic swtrap;
      logic fill;
      logic spill;
   } tvw_grp_t;

   function automatic tvw_grp_t tvw_group_f(input logic [TT_W-1:0] tt);
      tvw_grp_t g;
      g.spill   = (tt[8:6] == GRP_SPILL);
      g.fill    = (tt[8:6] == GRP_FILL);
      g.swtrap  = (tt[8:7] == 2'b10);
      g.hswtrap = (tt[8:7] == 2'b11) && (tt != 9'h1FF);
      return g;
   endfunction
endpackage

// File: rtl/tvw_classify.sv
module tvw_classify
   import tvw_pkg::*;
(
   input  logic [TT_W-1:0] tt_i,
   output tvw_grp_t        grp_o
);
   always_comb begin
      grp_o = tvw_group_f(tt_i);
      AST_GROUP_ONEHOT: assert ($onehot0(grp_o)); // R8
   end
endmodule

// File: rtl/tvw_vector.sv
module tvw_vector
   import tvw_pkg::*;
#(
   parameter int AW  = 64,
   parameter int TLW = 3
) (
   input  logic [TT_W-1:0] tt_i,
   input  logic [TLW-1:0]  tl_i,
   input  logic            hyp_i,
   input  logic [AW-1:0]   tbase_i,
   input  logic [AW-1:0]   hbase_i,
   output logic [AW-1:0]   pc_o,
   output logic [AW-1:0]   npc_o
);
   localparam logic [AW-1:0] WORD_STEP = AW'(4);

   if (AW < 16) begin : g_aw_chk
      $error("tvw_vector: AW must be at least 16");
   end
   if (TLW < 2) begin : g_tlw_chk
      $error("tvw_vector: TLW must be at least 2");
   end

   logic          upper_tl;
   logic [AW-1:0] pc_hyp;
   logic [AW-1:0] pc_norm;

   assign upper_tl = (tl_i > TLW'(1));
   assign pc_hyp   = {hbase_i[AW-1:14], tt_i, 5'b0};
   assign pc_norm  = {tbase_i[AW-1:15], upper_tl, tt_i, 5'b0};
   assign pc_o     = hyp_i ? pc_hyp : pc_norm;
   assign npc_o    = pc_o + WORD_STEP;
endmodule

// File: rtl/tvw_window.sv
module tvw_window
   import tvw_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int CW   = (NWIN > 2) ? $clog2(NWIN) : 1
) (
   input  logic [TT_W-1:0] tt_i,
   input  tvw_grp_t        grp_i,
   input  logic [CW-1:0]   cwp_i,
   input  logic [CW-1:0]   cansave_i,
   output logic [CW-1:0]   cwp_o
);
   localparam bit          POW2  = (NWIN & (NWIN - 1)) == 0;
   localparam int          EXT_W = CW + 2;
   localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

   if (NWIN < 2) begin : g_nwin_chk
      $error("tvw_window: NWIN must be at least 2");
   end

   logic [CW-1:0] dec_one;
   logic [CW-1:0] inc_one;
   logic [CW-1:0] spill_ptr;

   assign dec_one = (cwp_i == '0)  ? TOP : cwp_i - CW'(1);
   assign inc_one = (cwp_i == TOP) ? '0  : cwp_i + CW'(1);

   if (POW2) begin : g_pow2
      assign spill_ptr = cwp_i - cansave_i - CW'(2);
   end else begin : g_mod
      localparam logic [EXT_W-1:0] BIAS = EXT_W'(2 * NWIN - 2);
      logic [EXT_W-1:0] biased;
      assign biased    = EXT_W'(cwp_i) + BIAS - EXT_W'(cansave_i);
      assign spill_ptr = CW'(biased % EXT_W'(NWIN));
   end

   always_comb begin
      if (tt_i == TT_CLEAN_WIN) cwp_o = dec_one;
      else if (grp_i.spill)     cwp_o = spill_ptr;
      else if (grp_i.fill)      cwp_o = inc_one;
      else                      cwp_o = cwp_i;
   end
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
   import tvw_pkg::*;
#(
   parameter int AW         = 64,
   parameter int TLW        = 3,
   parameter int NWIN       = 8,
   parameter bit REGISTERED = 1'b1,
   parameter int CW         = (NWIN > 2) ? $clog2(NWIN) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_i,
   input  logic [8:0]      trap_type_i,
   input  logic [TLW-1:0]  trap_level_i,
   input  logic [AW-1:0]   tbase_i,
   input  logic [AW-1:0]   hbase_i,
   input  logic            hyper_mode_i,
   input  logic [CW-1:0]   cwp_i,
   input  logic [CW-1:0]   cansave_i,
   output logic [AW-1:0]   pc_o,
   output logic [AW-1:0]   npc_o,
   output logic [CW-1:0]   cwp_o,
   output logic            is_spill_o,
   output logic            is_fill_o,
   output logic            is_swtrap_o,
   output logic            is_hswtrap_o,
   output logic            valid_o
);
   localparam logic [CW:0] NWIN_V = (CW + 1)'(NWIN);

   typedef struct packed {
      logic [AW-1:0] pc;
      logic [AW-1:0] npc;
      logic [CW-1:0] cwp;
      tvw_grp_t      grp;
   } result_t;

   tvw_grp_t grp_c;
   result_t  res_c;
   result_t  res_out;

   tvw_classify u_cls (.tt_i(trap_type_i), .grp_o(grp_c));

   tvw_vector #(.AW(AW), .TLW(TLW)) u_vec (
      .tt_i(trap_type_i), .tl_i(trap_level_i), .hyp_i(hyper_mode_i),
      .tbase_i(tbase_i), .hbase_i(hbase_i),
      .pc_o(res_c.pc), .npc_o(res_c.npc)
   );

   tvw_window #(.NWIN(NWIN), .CW(CW)) u_win (
      .tt_i(trap_type_i), .grp_i(grp_c), .cwp_i(cwp_i),
      .cansave_i(cansave_i), .cwp_o(res_c.cwp)
   );

   assign res_c.grp = grp_c;

   if (REGISTERED) begin : g_reg
      result_t res_q;
      logic    valid_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q   <= '0;
            valid_q <= 1'b0;
         end else begin
            valid_q <= take_i;
            if (take_i) res_q <= res_c;
         end
      end

      assign res_out = res_q;
      assign valid_o = valid_q;

      AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         take_i |-> ({1'b0, cwp_i} < NWIN_V) && ({1'b0, cansave_i} < NWIN_V)); // R5
      AST_TT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
         take_i |=> pc_o[13:5] == $past(trap_type_i)); // R1
      AST_TL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
         (take_i && !hyper_mode_i) |=> pc_o[14] == ($past(trap_level_i) > TLW'(1))); // R2
      AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         valid_o |-> npc_o == pc_o + AW'(4)); // R3
      AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         valid_o |-> {1'b0, cwp_o} < NWIN_V); // R4
      AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !take_i |=> $stable(pc_o) && $stable(cwp_o) && !valid_o); // R9
   end else begin : g_comb
      assign res_out = res_c;
      assign valid_o = take_i;
   end

   assign pc_o         = res_out.pc;
   assign npc_o        = res_out.npc;
   assign cwp_o        = res_out.cwp;
   assign is_spill_o   = res_out.grp.spill;
   assign is_fill_o    = res_out.grp.fill;
   assign is_swtrap_o  = res_out.grp.swtrap;
   assign is_hswtrap_o = res_out.grp.hswtrap;
endmodule

// File: tb/trap_vector_unit_tb.sv
module trap_vector_unit_tb;
   localparam logic [63:0] TBASE = 64'h1234_5678_9ABC_FFFF;
   localparam logic [63:0] HBASE = 64'hCAFE_0000_0001_7FFF;
   localparam int NV = 13;

   // {tt, tl, hyp, cwp, cansave, exp_pc[15:0], exp_cwp, exp_grp{hsw,sw,fill,spill}}
   localparam logic [41:0] VEC [NV] = '{
      {9'h024, 3'd1, 1'b0, 3'd0, 3'd0, 16'h8480, 3'd7, 4'b0000},
      {9'h024, 3'd2, 1'b0, 3'd5, 3'd0, 16'hC480, 3'd4, 4'b0000},
      {9'h080, 3'd1, 1'b0, 3'd1, 3'd5, 16'h9000, 3'd2, 4'b0001},
      {9'h0BF, 3'd3, 1'b0, 3'd7, 3'd0, 16'hD7E0, 3'd5, 4'b0001},
      {9'h0C0, 3'd1, 1'b1, 3'd7, 3'd3, 16'h5800, 3'd0, 4'b0010},
      {9'h0FF, 3'd2, 1'b0, 3'd3, 3'd0, 16'hDFE0, 3'd4, 4'b0010},
      {9'h100, 3'd1, 1'b0, 3'd6, 3'd0, 16'hA000, 3'd6, 4'b0100},
      {9'h17F, 3'd1, 1'b1, 3'd2, 3'd0, 16'h6FE0, 3'd2, 4'b0100},
      {9'h180, 3'd4, 1'b1, 3'd3, 3'd0, 16'h7000, 3'd3, 4'b1000},
      {9'h1FE, 3'd0, 1'b0, 3'd4, 3'd0, 16'hBFC0, 3'd4, 4'b1000},
      {9'h1FF, 3'd5, 1'b0, 3'd1, 3'd0, 16'hFFE0, 3'd1, 4'b0000},
      {9'h008, 3'd1, 1'b1, 3'd0, 3'd0, 16'h4100, 3'd0, 4'b0000},
      {9'h0A0, 3'd1, 1'b0, 3'd0, 3'd7, 16'h9400, 3'd7, 4'b0001}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take_i = 1'b0;
   logic [8:0]  trap_type_i = '0;
   logic [2:0]  trap_level_i = '0;
   logic [63:0] tbase_i = TBASE;
   logic [63:0] hbase_i = HBASE;
   logic        hyper_mode_i = 1'b0;
   logic [2:0]  cwp_i = '0;
   logic [2:0]  cansave_i = '0;
   logic [63:0] pc_o, npc_o;
   logic [2:0]  cwp_o;
   logic        is_spill_o, is_fill_o, is_swtrap_o, is_hswtrap_o, valid_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   trap_vector_unit u_dut (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .trap_type_i(trap_type_i),
      .trap_level_i(trap_level_i), .tbase_i(tbase_i), .hbase_i(hbase_i),
      .hyper_mode_i(hyper_mode_i), .cwp_i(cwp_i), .cansave_i(cansave_i),
      .pc_o(pc_o), .npc_o(npc_o), .cwp_o(cwp_o), .is_spill_o(is_spill_o),
      .is_fill_o(is_fill_o), .is_swtrap_o(is_swtrap_o),
      .is_hswtrap_o(is_hswtrap_o), .valid_o(valid_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string cwp_tag(input logic [8:0] tt);
      if (tt == 9'h024)           return "R4 clean-window";
      else if (tt[8:6] == 3'b010) return "R5 spill";
      else if (tt[8:6] == 3'b011) return "R6 fill";
      else                        return "R7 unchanged";
   endfunction

   initial begin
      logic [63:0] last_pc;
      logic [2:0]  last_cwp;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 pc", pc_o, 64'h0);
      chk("R10 npc", npc_o, 64'h0);
      chk("R10 cwp", 64'(cwp_o), 64'h0);
      chk("R10 flags", 64'({is_hswtrap_o, is_swtrap_o, is_fill_o, is_spill_o, valid_o}), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 idle valid", 64'(valid_o), 64'h0);

      for (int i = 0; i < NV; i++) begin
         logic [63:0] exp_pc;
         logic [8:0]  tt;
         tt           = VEC[i][41:33];
         trap_type_i  = tt;
         trap_level_i = VEC[i][32:30];
         hyper_mode_i = VEC[i][29];
         cwp_i        = VEC[i][28:26];
         cansave_i    = VEC[i][25:23];
         take_i       = 1'b1;
         exp_pc = {(VEC[i][29] ? HBASE[63:16] : TBASE[63:16]), VEC[i][22:7]};
         @(negedge clk);
         chk(VEC[i][29] ? "R1 hyper pc" : "R2 normal pc", pc_o, exp_pc);
         chk("R3 npc", npc_o, exp_pc + 64'd4);
         chk(cwp_tag(tt), 64'(cwp_o), 64'(VEC[i][6:4]));
         chk("R8 groups", 64'({is_hswtrap_o, is_swtrap_o, is_fill_o, is_spill_o}), 64'(VEC[i][3:0]));
         chk("R9 valid after take", 64'(valid_o), 64'h1);
         last_pc  = exp_pc;
         last_cwp = VEC[i][6:4];
      end

      // R9: inputs change without take, outputs must hold
      take_i      = 1'b0;
      trap_type_i = 9'h0C5;
      cwp_i       = 3'd3;
      hyper_mode_i = 1'b1;
      @(negedge clk);
      chk("R9 valid drops", 64'(valid_o), 64'h0);
      @(negedge clk);
      chk("R9 pc held", pc_o, last_pc);
      chk("R9 cwp held", 64'(cwp_o), 64'(last_cwp));
      chk("R9 valid low", 64'(valid_o), 64'h0);

      // R10: reset after activity clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 pc after reset", pc_o, 64'h0);
      chk("R10 cwp after reset", 64'(cwp_o), 64'h0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule